// File: doc/BRIEF.md
# Branch Target Buffer with Presence-Based Prediction

This block is a direct-mapped store of branch targets, indexed by the low bits of a branch's program counter. A fetch unit presents a PC on the lookup port and gets back, in the same cycle, whether the buffer holds that branch, a taken prediction and the stored target. A resolving branch reports its PC, its outcome and its computed target on the update port.

The buffer keeps no counter. The presence of an entry is the prediction: a branch that was taken the last time it ran has an entry, and a branch that fell through has none. A taken resolution therefore installs or refreshes the entry. A not-taken resolution removes the entry if that branch owns it. An entry owned by an aliasing branch is left alone.

Top module: `btb_core`

## Requirements
- R1: A reset clears every entry. From the first cycle after reset, every lookup misses until a taken update is made.
- R2: The entry index is `pc[ALIGN+IDX_W-1:ALIGN]` and the tag is `pc[PC_W-1:ALIGN+IDX_W]`. A lookup hits only when the indexed entry is valid and its stored tag equals the lookup tag.
- R3: On a hit, `lk_hit` and `lk_taken` are 1 and `lk_target` carries the stored target. These values are combinational in the same cycle as `lk_pc`.
- R4: On a miss, `lk_hit`, `lk_taken` and `lk_target` are all 0, which predicts fall-through.
- R5: An update with `upd_en`=1 and `upd_taken`=1 writes a valid entry with the update's tag and target. Lookups see it from the next cycle.
- R6: An update with `upd_en`=1 and `upd_taken`=0 invalidates the indexed entry when that entry is valid and its tag matches.
- R7: A not-taken update leaves the indexed entry unchanged when that entry is invalid or holds a different tag.
- R8: A taken update to an entry that is valid but holds a different tag replaces the entry's tag and target.
- R9: When a lookup and an update address the same entry in one cycle, the lookup returns the contents from before the update.
- R10: While `upd_en`=0, no entry changes, whatever values the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | PC of the branch being fetched |
| lk_hit | output | 1 | The buffer holds the lookup branch |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | TGT_W | Predicted target, 0 on a miss |
| upd_en | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Outcome of the resolved branch, 1 = taken |
| upd_target | input | TGT_W | Computed target of the resolved branch |

## Verification
The bench uses a small index width so that branches alias on purpose. Targeted sequences separate an owner's eviction from an alias's attempted eviction, and an alias overwrite from a plain fill. Same-entry lookup-with-update cycles show whether the old or the new contents are read. A single branch is driven with the outcome pattern N-N-N-T-N-N-N to check that each outcome is predicted as the previous one. A long random run over a few tags per index mixes fills, evictions, idle update cycles and a mid-run reset, and the bench compares every cycle against a behavioural model.

// File: rtl/btb_pkg.sv
package btb_pkg;
  parameter int DEF_PC_W  = 32;
  parameter int DEF_IDX_W = 11;
  parameter int DEF_ALIGN = 2;
  parameter int DEF_TGT_W = 32;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_FILL = 2'd1,
    ACT_DROP = 2'd2
  } upd_act_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int IDX_W = 11,
  parameter int TAG_W = 19,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic [TGT_W-1:0] wtgt,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output logic [TGT_W-1:0] ra_tgt,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = TAG_W + TGT_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] ent_a;
  logic [ENT_W-1:0] ent_b;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= {wtag, wtgt};
  end

  assign ent_a  = mem[ra_idx];
  assign ent_b  = mem[rb_idx];
  assign ra_tag = ent_a[ENT_W-1:TGT_W];
  assign ra_tgt = ent_a[TGT_W-1:0];
  assign rb_tag = ent_b[ENT_W-1:TGT_W];

  // R5: a write lands in the addressed slot
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(widx)] == $past({wtag, wtgt})));
endmodule

// File: rtl/btb_valid.sv
module btb_valid
  import btb_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  upd_act_e         act,
  input  logic [IDX_W-1:0] widx,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_v,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_v
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      case (act)
        ACT_FILL: valid_q[widx] <= 1'b1;
        ACT_DROP: valid_q[widx] <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign ra_v = valid_q[ra_idx];
  assign rb_v = valid_q[rb_idx];

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (valid_q == '0));

  assert_fill_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_FILL) |=> valid_q[$past(widx)]);

  assert_drop_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_DROP) |=> !valid_q[$past(widx)]);

  assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_NONE) |=> $stable(valid_q));
endmodule

// File: rtl/btb_upd_ctl.sv
module btb_upd_ctl
  import btb_pkg::*;
#(
  parameter int TAG_W = 19
) (
  input  logic             upd_en,
  input  logic             upd_taken,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             cur_v,
  input  logic [TAG_W-1:0] cur_tag,
  output upd_act_e         act,
  output logic             store_we
);
  logic owner;

  assign owner = cur_v && (cur_tag == upd_tag);

  always_comb begin
    act = ACT_NONE;
    if (upd_en) begin
      if (upd_taken)  act = ACT_FILL;
      else if (owner) act = ACT_DROP;
    end
  end

  assign store_we = (act == ACT_FILL);
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int TAG_W = 19,
  parameter int TGT_W = 32
) (
  input  logic             ent_v,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TGT_W-1:0] ent_tgt,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic [TGT_W-1:0] tgt
);
  assign hit = ent_v && (ent_tag == req_tag);
  assign tgt = hit ? ent_tgt : '0;
endmodule

// File: rtl/btb_core.sv
module btb_core
  import btb_pkg::*;
#(
  parameter int PC_W  = DEF_PC_W,
  parameter int IDX_W = DEF_IDX_W,
  parameter int ALIGN = DEF_ALIGN,
  parameter int TGT_W = DEF_TGT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic             lk_taken,
  output logic [TGT_W-1:0] lk_target,
  input  logic             upd_en,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic [TGT_W-1:0] upd_target
);
  localparam int TAG_LO = ALIGN + IDX_W;
  localparam int TAG_W  = PC_W - TAG_LO;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [TGT_W-1:0] a_tgt;
  logic             a_v, b_v;
  logic             we;
  upd_act_e         act;

  assign lk_idx = lk_pc[TAG_LO-1:ALIGN];
  assign up_idx = upd_pc[TAG_LO-1:ALIGN];
  assign lk_tag = lk_pc[PC_W-1:TAG_LO];
  assign up_tag = upd_pc[PC_W-1:TAG_LO];

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
    .clk(clk), .rst(rst), .we(we), .widx(up_idx), .wtag(up_tag), .wtgt(upd_target),
    .ra_idx(lk_idx), .ra_tag(a_tag), .ra_tgt(a_tgt),
    .rb_idx(up_idx), .rb_tag(b_tag)
  );

  btb_valid #(.IDX_W(IDX_W)) u_valid (
    .clk(clk), .rst(rst), .act(act), .widx(up_idx),
    .ra_idx(lk_idx), .ra_v(a_v), .rb_idx(up_idx), .rb_v(b_v)
  );

  btb_upd_ctl #(.TAG_W(TAG_W)) u_ctl (
    .upd_en(upd_en), .upd_taken(upd_taken), .upd_tag(up_tag),
    .cur_v(b_v), .cur_tag(b_tag), .act(act), .store_we(we)
  );

  btb_match #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_match (
    .ent_v(a_v), .ent_tag(a_tag), .ent_tgt(a_tgt), .req_tag(lk_tag),
    .hit(lk_hit), .tgt(lk_target)
  );

  assign lk_taken = lk_hit;
endmodule

// File: tb/tb_btb_core.sv
`timescale 1ns/1ps
module tb_btb_core;
  localparam int PC_W = 16, IDX_W = 4, ALIGN = 2, TGT_W = 16;
  localparam int N = 1 << IDX_W;

  logic clk = 0, rst = 1;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic upd_en = 0, upd_taken = 0;
  logic [TGT_W-1:0] upd_target = '0;
  logic lk_hit, lk_taken;
  logic [TGT_W-1:0] lk_target;

  int errors = 0, checks = 0;
  bit     m_v  [N];
  int     m_pc [N];
  int     m_tg [N];

  always #2 clk = ~clk;

  btb_core #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN), .TGT_W(TGT_W)) dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(lk_target), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target));

  function automatic logic [PC_W-1:0] mk(int tag, int idx);
    return PC_W'((tag << (ALIGN + IDX_W)) | (idx << ALIGN));
  endfunction

  task automatic clear_model();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  // drive one cycle, check lookup against the model, then advance the model
  task automatic step(string req, logic [PC_W-1:0] lp, bit en, logic [PC_W-1:0] up,
                      bit tk, logic [TGT_W-1:0] tg);
    int li, ui;
    bit eh;
    int et;
    @(negedge clk);
    lk_pc = lp; upd_en = en; upd_pc = up; upd_taken = tk; upd_target = tg;
    #1;
    li = int'(lp[ALIGN +: IDX_W]);
    eh = m_v[li] && ((m_pc[li] >> (ALIGN + IDX_W)) == int'(lp >> (ALIGN + IDX_W)));
    et = eh ? m_tg[li] : 0;
    checks++;
    if (lk_hit !== eh || lk_taken !== eh || int'(lk_target) != et) begin
      errors++;
      $display("FAIL %s pc=%h: hit=%b taken=%b tgt=%h expected hit=%b taken=%b tgt=%h",
               req, lp, lk_hit, lk_taken, lk_target, eh, eh, et[TGT_W-1:0]);
    end
    if (en) begin
      ui = int'(up[ALIGN +: IDX_W]);
      if (tk) begin
        m_v[ui] = 1; m_pc[ui] = int'(up); m_tg[ui] = int'(tg);
      end else if (m_v[ui] && ((m_pc[ui] >> (ALIGN + IDX_W)) == int'(up >> (ALIGN + IDX_W)))) begin
        m_v[ui] = 0;
      end
    end
  endtask

  task automatic look(string req, logic [PC_W-1:0] lp);
    step(req, lp, 0, '0, 0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; upd_en = 0;
    repeat (2) @(negedge clk);
    rst = 0; clear_model();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit pat [7];
    pat = '{0, 0, 0, 1, 0, 0, 0};
    clear_model();
    do_reset();
    // R1: reset leaves nothing behind
    for (int i = 0; i < N; i++) look("R1", mk(i % 3, i));
    // R9: fill and look up the same entry in one cycle -> old (miss)
    step("R9", mk(1, 3), 1, mk(1, 3), 1, 16'h1234);
    look("R3", mk(1, 3));
    look("R2", mk(2, 3));
    look("R4", mk(1, 4));
    // R7: alias not-taken leaves owner's entry
    step("R7", mk(5, 0), 1, mk(2, 3), 0, 16'h0);
    look("R7", mk(1, 3));
    // R6: owner not-taken evicts
    step("R6", mk(5, 0), 1, mk(1, 3), 0, 16'h0);
    look("R6", mk(1, 3));
    // R8: alias taken overwrites
    step("R5", mk(0, 0), 1, mk(1, 5), 1, 16'hAAAA);
    step("R8", mk(1, 5), 1, mk(2, 5), 1, 16'hBBBB);
    look("R8", mk(1, 5));
    look("R8", mk(2, 5));
    // R10: disabled update changes nothing
    step("R10", mk(0, 0), 0, mk(3, 7), 1, 16'h7777);
    look("R10", mk(3, 7));
    step("R10", mk(0, 0), 0, mk(2, 5), 0, 16'h0);
    look("R10", mk(2, 5));
    // R9: evict while looking up -> still sees old hit
    step("R9", mk(2, 5), 1, mk(2, 5), 0, 16'h0);
    look("R9", mk(2, 5));
    // R5/R6: outcome pattern N N N T N N N, each predicted as the previous
    for (int k = 0; k < 7; k++)
      step(pat[k] ? "R5" : "R6", mk(4, 9), 1, mk(4, 9), pat[k], 16'h0900 + 16'(k));
    look("R6", mk(4, 9));
    // R2: random mix with aliasing
    for (int k = 0; k < 600; k++)
      step("R2", mk($urandom_range(0, 2), $urandom_range(0, N - 1)),
           bit'($urandom_range(0, 3) != 0),
           mk($urandom_range(0, 2), $urandom_range(0, N - 1)),
           bit'($urandom_range(0, 1)), 16'($urandom));
    // R1: reset in the middle of use
    do_reset();
    for (int i = 0; i < N; i++) look("R1", mk(i % 3, i));
    for (int k = 0; k < 200; k++)
      step("R2", mk($urandom_range(0, 1), $urandom_range(0, N - 1)),
           bit'($urandom_range(0, 1)),
           mk($urandom_range(0, 1), $urandom_range(0, N - 1)),
           bit'($urandom_range(0, 2) != 0), 16'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule